// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It combines two predictors and picks one of them for each branch. The first follows the global path: it holds one shift register with the most recent resolved outcomes, and it selects a 2-bit counter with the branch index XORed with that register. The second follows each branch on its own: every branch index has a history register of its own, and that history selects a 2-bit counter in a second table. A third table holds one 2-bit chooser counter for each branch index. The chooser decides which predictor gives the final answer.

The fetch stage presents a PC on the lookup port. The prediction and a snapshot come back in the same cycle. The snapshot holds both component predictions and both counter indices. When the branch resolves, the pipeline returns the PC, the actual outcome and that snapshot on the update port. Training then hits exactly the counters that made the prediction, even if the histories have moved on since the lookup.

Top module: `bp_tournament`

## Requirements
- R1: While reset is held, every direction counter becomes 01, every chooser counter becomes 10 and every history register becomes zero. The first lookup after reset therefore predicts not-taken, and both component bits of the snapshot are 0.
- R2: A direction counter predicts taken when it holds 10 or 11. It predicts not-taken when it holds 00 or 01.
- R3: On an update, each component counter moves one step toward the actual outcome and saturates at 00 and 11. A counter in a strong state needs two consecutive opposite outcomes before its prediction flips.
- R4: The global history register shifts left by one position on every cycle that has upd_valid high, and the outcome enters bit 0. It holds its value in cycles without an update.
- R5: The global counter index is the branch index XORed with the global history. The branch index is lk_pc[PC_LSB+IDX_W-1:PC_LSB], zero-extended to GHIST_W bits. The snapshot is laid out as {global prediction, local prediction, global index (GHIST_W bits), local history (LHIST_W bits)}, with the global prediction in the MSB.
- R6: Each branch index has its own local history. That history selects the local counter. An update shifts the outcome into bit 0 of the history of the updated index only. Two PCs with the same index bits share one history.
- R7: The chooser for the updated index moves one step toward global when the two snapshot predictions differ and the global one matched the outcome. It moves one step toward local when they differ and the local one matched. It is unchanged when the two predictions agree. A chooser value of 10 or 11 selects global.
- R8: lk_taken is the global prediction when the chooser of the lookup index selects global, and the local prediction otherwise. When the two predictions agree, lk_taken equals them.
- R9: A lookup and an update may happen in the same cycle. The lookup then returns values computed from the table and history contents before that update.
- R10: A branch that repeats a fixed pattern with a period of at most LHIST_W+1 is predicted without error once both predictors have trained on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | PC of the branch being looked up |
| lk_taken | output | 1 | Final direction prediction, 1 = taken |
| lk_snap | output | 2+GHIST_W+LHIST_W | Snapshot to return with the update |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_snap | input | 2+GHIST_W+LHIST_W | Snapshot that lookup returned for this branch |

## Verification
The bound checker checks four behaviours on every cycle. It checks the clean state right after reset, that the global history shifts in the outcome on each update, that the global history holds still between updates, and that lk_taken follows the two components whenever they agree. Counter saturation and hysteresis, the chooser training rule, the sharing of local histories between aliased PCs, read-before-write ordering and pattern learning all need stored history to be visible. Only the bench scenarios show them. There a behavioural model compares the prediction and the full snapshot in every cycle.

// File: rtl/bp_tourn_pkg.sv
package bp_tourn_pkg;
   typedef logic [1:0] ctr2_t;

   localparam ctr2_t CTR_STRONG_NT = 2'b00;
   localparam ctr2_t CTR_WEAK_NT   = 2'b01;
   localparam ctr2_t CTR_WEAK_T    = 2'b10;
   localparam ctr2_t CTR_STRONG_T  = 2'b11;

   // one saturating step toward the given direction
   function automatic ctr2_t ctr_train(input ctr2_t cur, input logic up);
      ctr2_t nxt;
      if (up) nxt = (cur == CTR_STRONG_T) ? cur : ctr2_t'(cur + 2'b01);
      else    nxt = (cur == CTR_STRONG_NT) ? cur : ctr2_t'(cur - 2'b01);
      return nxt;
   endfunction

   function automatic logic ctr_dir(input ctr2_t cur);
      return cur[1];
   endfunction
endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
   import bp_tourn_pkg::*;
#(
   parameter int    IDX_W   = 6,
   parameter ctr2_t RST_VAL = CTR_WEAK_NT
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr2_t            rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);
   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W < 1) begin : g_bad_idx
      $error("bp_ctr_table: IDX_W must be at least 1");
   end

   ctr2_t tbl_q [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) tbl_q[i] <= RST_VAL;
      end else if (wr_en) begin
         tbl_q[wr_idx] <= ctr_train(tbl_q[wr_idx], wr_up);
      end
   end

   // reads see the contents from before a write in the same cycle
   assign rd_ctr = tbl_q[rd_idx];
endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
   parameter int IDX_W  = 6,
   parameter int HIST_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HIST_W-1:0] rd_hist,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_bit
);
   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W < 1 || HIST_W < 1) begin : g_bad_w
      $error("bp_hist_table: IDX_W and HIST_W must be at least 1");
   end

   logic [HIST_W-1:0] hist_q [DEPTH];
   logic [HIST_W-1:0] shifted;

   if (HIST_W == 1) begin : g_one
      assign shifted = wr_bit;
   end else begin : g_many
      assign shifted = {hist_q[wr_idx][HIST_W-2:0], wr_bit};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
      end else if (wr_en) begin
         hist_q[wr_idx] <= shifted;
      end
   end

   assign rd_hist = hist_q[rd_idx];
endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic              shift_bit,
   output logic [HIST_W-1:0] hist
);
   if (HIST_W < 2) begin : g_bad_w
      $error("bp_ghist: HIST_W must be at least 2");
   end

   logic [HIST_W-1:0] hist_q;

   always_ff @(posedge clk) begin
      if (rst)           hist_q <= '0;
      else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
   end

   assign hist = hist_q;
endmodule

// File: rtl/bp_tournament.sv
module bp_tournament
   import bp_tourn_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int PC_LSB  = 2,
   parameter int IDX_W   = 6,
   parameter int GHIST_W = 8,
   parameter int LHIST_W = 6,
   localparam int SNAP_W = 2 + GHIST_W + LHIST_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PC_W-1:0]   lk_pc,
   output logic              lk_taken,
   output logic [SNAP_W-1:0] lk_snap,
   input  logic              upd_valid,
   input  logic [PC_W-1:0]   upd_pc,
   input  logic              upd_taken,
   input  logic [SNAP_W-1:0] upd_snap
);
   if (PC_LSB + IDX_W > PC_W) begin : g_bad_pc
      $error("bp_tournament: index bits exceed PC width");
   end
   if (GHIST_W < 2 || LHIST_W < 1 || IDX_W < 1) begin : g_bad_hist
      $error("bp_tournament: history or index width too small");
   end

   localparam int SNAP_GP  = SNAP_W - 1;
   localparam int SNAP_LP  = SNAP_W - 2;
   localparam int SNAP_GI  = LHIST_W;

   logic [IDX_W-1:0]   lk_idx, upd_idx;
   logic [GHIST_W-1:0] ghr_q;
   logic [GHIST_W-1:0] lk_gidx;
   logic [LHIST_W-1:0] lk_lhist;
   ctr2_t              g_ctr, l_ctr, c_ctr;
   logic               g_pred, l_pred;

   assign lk_idx  = lk_pc[PC_LSB +: IDX_W];
   assign upd_idx = upd_pc[PC_LSB +: IDX_W];

   // fold the branch index with the global history
   if (GHIST_W <= IDX_W) begin : g_fold_trunc
      assign lk_gidx = lk_idx[GHIST_W-1:0] ^ ghr_q;
   end else begin : g_fold_ext
      assign lk_gidx = {{(GHIST_W-IDX_W){1'b0}}, lk_idx} ^ ghr_q;
   end

   // snapshot fields returned on update
   logic               u_gp, u_lp;
   logic [GHIST_W-1:0] u_gidx;
   logic [LHIST_W-1:0] u_lidx;
   assign u_gp   = upd_snap[SNAP_GP];
   assign u_lp   = upd_snap[SNAP_LP];
   assign u_gidx = upd_snap[SNAP_GI +: GHIST_W];
   assign u_lidx = upd_snap[0 +: LHIST_W];

   bp_ghist #(.HIST_W(GHIST_W)) i_ghist (
      .clk(clk), .rst(rst),
      .shift_en(upd_valid), .shift_bit(upd_taken),
      .hist(ghr_q)
   );

   bp_hist_table #(.IDX_W(IDX_W), .HIST_W(LHIST_W)) i_lhist (
      .clk(clk), .rst(rst),
      .rd_idx(lk_idx), .rd_hist(lk_lhist),
      .wr_en(upd_valid), .wr_idx(upd_idx), .wr_bit(upd_taken)
   );

   bp_ctr_table #(.IDX_W(GHIST_W), .RST_VAL(CTR_WEAK_NT)) i_gtab (
      .clk(clk), .rst(rst),
      .rd_idx(lk_gidx), .rd_ctr(g_ctr),
      .wr_en(upd_valid), .wr_idx(u_gidx), .wr_up(upd_taken)
   );

   bp_ctr_table #(.IDX_W(LHIST_W), .RST_VAL(CTR_WEAK_NT)) i_ltab (
      .clk(clk), .rst(rst),
      .rd_idx(lk_lhist), .rd_ctr(l_ctr),
      .wr_en(upd_valid), .wr_idx(u_lidx), .wr_up(upd_taken)
   );

   // chooser: high half selects global; trains only on disagreement
   bp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_T)) i_choose (
      .clk(clk), .rst(rst),
      .rd_idx(lk_idx), .rd_ctr(c_ctr),
      .wr_en(upd_valid && (u_gp != u_lp)), .wr_idx(upd_idx),
      .wr_up(u_gp == upd_taken)
   );

   assign g_pred   = ctr_dir(g_ctr);
   assign l_pred   = ctr_dir(l_ctr);
   assign lk_taken = ctr_dir(c_ctr) ? g_pred : l_pred;
   assign lk_snap  = {g_pred, l_pred, lk_gidx, lk_lhist};
endmodule

// File: rtl/bp_tournament_chk.sv
module bp_tournament_chk #(
   parameter int GHIST_W = 8,
   parameter int SNAP_W  = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              lk_taken,
   input logic [SNAP_W-1:0] lk_snap,
   input logic              upd_valid,
   input logic              upd_taken,
   input logic [GHIST_W-1:0] ghr
);
   logic past_ok;
   always_ff @(posedge clk) past_ok <= 1'b1;

   // R1: first cycle after reset sees untouched tables
   assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(rst)) |-> (!lk_taken && !lk_snap[SNAP_W-1] && !lk_snap[SNAP_W-2]));

   // R4: history shifts in the resolved outcome
   assert_ghr_shift_R4: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(rst) && $past(upd_valid)) |->
         (ghr == {$past(ghr[GHIST_W-2:0]), $past(upd_taken)}));

   // R4: history holds without an update
   assert_ghr_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(rst) && !$past(upd_valid)) |-> $stable(ghr));

   // R8: agreeing components decide the output
   assert_agree_select_R8: assert property (@(posedge clk) disable iff (rst)
      (lk_snap[SNAP_W-1] == lk_snap[SNAP_W-2]) |-> (lk_taken == lk_snap[SNAP_W-1]));
endmodule

bind bp_tournament bp_tournament_chk #(.GHIST_W(GHIST_W), .SNAP_W(SNAP_W)) i_chk (
   .clk(clk), .rst(rst), .lk_taken(lk_taken), .lk_snap(lk_snap),
   .upd_valid(upd_valid), .upd_taken(upd_taken), .ghr(ghr_q)
);

// File: tb/test_bp_tournament.sv
module test_bp_tournament;
   localparam int PC_W = 32, PC_LSB = 2, IDX_W = 6, GHIST_W = 8, LHIST_W = 6;
   localparam int SNAP_W = 2 + GHIST_W + LHIST_W;
   localparam int NIDX = 1 << IDX_W, NG = 1 << GHIST_W, NL = 1 << LHIST_W;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst;
   logic [PC_W-1:0]   lk_pc, upd_pc;
   logic              lk_taken, upd_valid, upd_taken;
   logic [SNAP_W-1:0] lk_snap, upd_snap;

   bp_tournament #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W),
                   .GHIST_W(GHIST_W), .LHIST_W(LHIST_W)) i_bp_tournament (
      .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_snap(lk_snap),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_snap(upd_snap)
   );

   int n_cmp = 0, n_bad = 0;
   int gc [NG];
   int lc [NL];
   int ch [NIDX];
   int lh [NIDX];
   int ghr;
   logic [SNAP_W-1:0] last_snap;
   logic              last_pred;

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      summary();
      $finish;
   end

   function automatic int sat(int c, bit up);
      if (up) return (c == 3) ? 3 : c + 1;
      return (c == 0) ? 0 : c - 1;
   endfunction

   function automatic int pidx(logic [PC_W-1:0] pc);
      return int'((pc >> PC_LSB) % NIDX);
   endfunction

   task automatic model_reset();
      foreach (gc[i]) gc[i] = 1;
      foreach (lc[i]) lc[i] = 1;
      foreach (ch[i]) ch[i] = 2;
      foreach (lh[i]) lh[i] = 0;
      ghr = 0;
   endtask

   function automatic logic [SNAP_W-1:0] m_snap(logic [PC_W-1:0] pc);
      int pi = pidx(pc);
      int gi = (pi ^ ghr) % NG;
      int li = lh[pi];
      logic gp = (gc[gi] >= 2);
      logic lp = (lc[li] >= 2);
      return {gp, lp, GHIST_W'(gi), LHIST_W'(li)};
   endfunction

   function automatic logic m_pred(logic [PC_W-1:0] pc);
      logic [SNAP_W-1:0] s = m_snap(pc);
      return (ch[pidx(pc)] >= 2) ? s[SNAP_W-1] : s[SNAP_W-2];
   endfunction

   task automatic model_update(logic [PC_W-1:0] pc, bit t, logic [SNAP_W-1:0] s);
      int pi = pidx(pc);
      int gi = int'(s[LHIST_W +: GHIST_W]);
      int li = int'(s[0 +: LHIST_W]);
      bit gp = s[SNAP_W-1];
      bit lp = s[SNAP_W-2];
      gc[gi] = sat(gc[gi], t);
      lc[li] = sat(lc[li], t);
      if (gp != lp) ch[pi] = sat(ch[pi], gp == t);
      lh[pi] = ((lh[pi] << 1) | int'(t)) % NL;
      ghr = ((ghr << 1) | int'(t)) % NG;
   endtask

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // one clock: drive, compare against model state before the edge, then train model
   task automatic cyc(logic [PC_W-1:0] lpc, bit uv, logic [PC_W-1:0] upc, bit ut,
                      logic [SNAP_W-1:0] us, string tag);
      @(negedge clk);
      lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_snap = us;
      #1;
      last_snap = m_snap(lpc);
      last_pred = m_pred(lpc);
      chk({tag, " R8 prediction"}, 32'(lk_taken), 32'(last_pred));
      chk({tag, " R5 snapshot"}, 32'(lk_snap), 32'(last_snap));
      @(posedge clk);
      if (uv) model_update(upc, ut, us);
   endtask

   // look up, then resolve in the following cycle
   task automatic branch(logic [PC_W-1:0] pc, bit t, string tag, output logic pred);
      logic [SNAP_W-1:0] s;
      cyc(pc, 1'b0, '0, 1'b0, '0, tag);
      s = last_snap;
      pred = last_pred;
      cyc(pc, 1'b1, pc, t, s, tag);
   endtask

   initial begin
      logic p;
      int good;
      logic [15:0] lfsr;
      logic [PC_W-1:0] prev_pc;
      logic [SNAP_W-1:0] prev_snap;
      bit prev_t;

      rst = 1'b1; lk_pc = '0; upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0; upd_snap = '0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1: clean state after reset
      cyc(32'h0000_0100, 0, '0, 0, '0, "R1");
      chk("R1 not-taken after reset", 32'(lk_taken), 32'd0);
      chk("R1 component bits zero", 32'(lk_snap[SNAP_W-1 -: 2]), 32'd0);
      cyc(32'h0000_2004, 0, '0, 0, '0, "R1");
      cyc(32'h0000_3ffc, 0, '0, 0, '0, "R1");

      // R2 R3: strong training, then brief reversals
      for (int i = 0; i < 12; i++) branch(32'h0000_0400, 1'b1, "R2 R3 taken", p);
      for (int i = 0; i < 3; i++)  branch(32'h0000_0400, 1'b0, "R3 reversal", p);
      for (int i = 0; i < 6; i++)  branch(32'h0000_0400, i[0], "R3 alternate", p);

      // R6: aliased PCs share one history; distinct PC keeps its own
      for (int i = 0; i < 8; i++) begin
         branch(32'h0000_1000, 1'b1, "R6 alias a", p);
         branch(32'h0000_1100, 1'b0, "R6 alias b", p);
         branch(32'h0000_1004, i[1], "R6 distinct", p);
      end

      // R10: period-3 pattern N N T becomes fully predicted
      good = 0;
      for (int i = 0; i < 60; i++) begin
         branch(32'h0000_0800, (i % 3) == 2, "R10 pattern", p);
         if (i >= 48 && p == ((i % 3) == 2)) good++;
      end
      chk("R10 pattern learned", 32'(good), 32'd12);

      // R7: correlated pair, second follows first, drives chooser training
      for (int i = 0; i < 30; i++) begin
         bit t = ((i * 7) % 5) < 2;
         branch(32'h0000_0a00, t, "R7 leader", p);
         branch(32'h0000_0a40, t, "R7 follower", p);
      end

      // R9 R4: overlapped lookup and update, often on the same PC
      lfsr = 16'hACE1;
      prev_pc = 32'h0000_2000; prev_t = 1'b0;
      cyc(prev_pc, 0, '0, 0, '0, "R9 start");
      prev_snap = last_snap;
      for (int i = 0; i < 500; i++) begin
         logic [PC_W-1:0] pc;
         bit t;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         pc = 32'h0000_2000 + 32'(lfsr[2:0]) * 4 + ((lfsr[3] && lfsr[4]) ? 32'h100 : 32'h0);
         if (lfsr[5]) pc = prev_pc;
         t = (lfsr[2:0] < 3) ? lfsr[7] : (lfsr[2:0] != 3'd5);
         cyc(pc, 1'b1, prev_pc, prev_t, prev_snap, "R9 R4 overlap");
         prev_snap = last_snap; prev_pc = pc; prev_t = t;
      end
      cyc(prev_pc, 1'b1, prev_pc, prev_t, prev_snap, "R9 drain");
      cyc(32'h0000_2000, 0, '0, 0, '0, "R4 hold");

      summary();
      $finish;
   end
endmodule